// File: doc/BRIEF.md
# Watchdog Reset Gating Controller

This block sits on the power-management side, between a watchdog timer's reset request and the system reset controller. Software uses it to decide whether a watchdog expiry actually resets the system. A gating bit blocks or passes the request, and its sense is fixed when the block is built. An auto-disable bit drops the request while the owning processor is itself held in reset. A counter-enable bit drives a level that lets the watchdog count. A sticky status bit records that the watchdog caused the last system reset.

The block is reset only by power-on reset, so the status bit survives the system reset that the block itself forwards. Software clears the status bit by writing 1 to it. Each of the four registers holds a single live bit at a parameter-chosen position. Word address 0 is the gate, 1 is auto-disable, 2 is counter-enable and 3 is status. All other bits ignore writes and read as zero.

Top module: `wdt_reset_gate`

## Requirements
- R1: After power-on reset, the request path is blocked. The counter-enable output is 0. The gate register reads as a 1 at its bit position with normal polarity and as 0 with inverted polarity. The auto-disable, counter-enable and status registers read 0.
- R2: With normal polarity (INVERT_MASK=0), a 1 in the gate bit blocks the request and a 0 lets it through.
- R3: With inverted polarity (INVERT_MASK=1), a 1 in the gate bit lets the request through and a 0 blocks it.
- R4: While the auto-disable bit is 1 and the processor-in-reset input is high, the request is dropped. While the auto-disable bit is 0, the processor-in-reset input has no effect on the forwarded reset.
- R5: The forwarded reset is registered. It equals the request AND not-blocked AND not (auto-disable AND processor-in-reset), as sampled at the previous clock edge.
- R6: The counter-enable output follows the counter-enable bit. It takes the new value in the cycle after the write edge.
- R7: The status bit is set at the same edge at which the forwarded reset rises. It stays set once the request goes away.
- R8: Writing 1 to the status bit position at address 3 clears it, and writing 0 there leaves it unchanged. If a clear and a new set arrive at the same edge, the set wins.
- R9: Each register takes writes only at its configured bit position. A read with bus_sel=1 and bus_wr=0 returns that bit in place and zeros elsewhere. When no read is in progress, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| wdt_req | input | 1 | Reset request from the watchdog |
| cpu_in_reset | input | 1 | Owning processor is held in reset |
| wdt_rst_out | output | 1 | Gated, registered reset request to the reset controller |
| wdt_cnt_en | output | 1 | Lets the watchdog counter run |

## Verification
The forwarded reset and the status bit both change one clock edge after the inputs and register bits that produce them. The counter-enable level and register contents change at the write edge itself, and read data is combinational within the same cycle. The bench drives inputs on the falling edge and steps a behavioural model at the rising edge. It compares the outputs 1 ns after that edge, and it makes its directed checks just after a falling edge, before and after the edge that is due. Two instances with opposite gate polarity and different bit positions share the stimulus.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int unsigned WRG_ADDR_W = 2;

  typedef enum logic [WRG_ADDR_W-1:0] {
    WRG_GATE    = 2'd0,
    WRG_AUTODIS = 2'd1,
    WRG_CNTEN   = 2'd2,
    WRG_STATUS  = 2'd3
  } wrg_reg_e;

  // Whether the stored gate bit blocks the request, given the build polarity.
  function automatic logic wrg_blocked(logic gate_field, logic inverted);
    return gate_field ^ inverted;
  endfunction

  // Value of the gate bit that blocks the request at power-on.
  function automatic logic wrg_gate_reset(logic inverted);
    return ~inverted;
  endfunction

  // Combinational decision to forward the request.
  function automatic logic wrg_forward(logic req, logic blocked, logic autodis, logic in_rst);
    return req & ~blocked & ~(autodis & in_rst);
  endfunction
endpackage

// File: rtl/wrg_regs.sv
module wrg_regs
  import wrg_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned GATE_POS    = 4,
  parameter int unsigned AUTODIS_POS = 2,
  parameter int unsigned CNTEN_POS   = 0,
  parameter int unsigned STAT_POS    = 1,
  parameter bit          INVERT_MASK = 1'b0
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [WRG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  stat_bit,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  gate_bit,
  output logic                  autodis_bit,
  output logic                  cnten_bit,
  output logic                  stat_clr,
  output logic                  cnten_wr
);
  localparam int unsigned CTL_N = 3;
  localparam int unsigned CTL_POS [CTL_N] = '{GATE_POS, AUTODIS_POS, CNTEN_POS};
  localparam logic        CTL_RST [CTL_N] = '{wrg_gate_reset(INVERT_MASK), 1'b0, 1'b0};

  logic             wr_en, rd_en;
  logic [CTL_N-1:0] ctl_q, ctl_wr;
  logic             unused_wdata;

  assign wr_en        = bus_sel & bus_wr;
  assign rd_en        = bus_sel & ~bus_wr;
  assign unused_wdata = ^bus_wdata;

  for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
    logic q;
    assign ctl_wr[g] = wr_en && (bus_addr == WRG_ADDR_W'(g));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         q <= CTL_RST[g];
      else if (ctl_wr[g]) q <= bus_wdata[CTL_POS[g]];
    end
    assign ctl_q[g] = q;
  end

  assign gate_bit    = ctl_q[0];
  assign autodis_bit = ctl_q[1];
  assign cnten_bit   = ctl_q[2];
  assign cnten_wr    = ctl_wr[2];
  assign stat_clr    = wr_en && (bus_addr == WRG_STATUS) && bus_wdata[STAT_POS];

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (wrg_reg_e'(bus_addr))
        WRG_GATE:    bus_rdata[GATE_POS]    = ctl_q[0];
        WRG_AUTODIS: bus_rdata[AUTODIS_POS] = ctl_q[1];
        WRG_CNTEN:   bus_rdata[CNTEN_POS]   = ctl_q[2];
        WRG_STATUS:  bus_rdata[STAT_POS]    = stat_bit;
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wrg_gate.sv
module wrg_gate
  import wrg_pkg::*;
#(
  parameter bit INVERT_MASK = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic wdt_req,
  input  logic cpu_in_reset,
  input  logic gate_bit,
  input  logic autodis_bit,
  output logic req_blocked,
  output logic fwd_now,
  output logic wdt_rst_out
);
  assign req_blocked = wrg_blocked(gate_bit, INVERT_MASK);
  assign fwd_now     = wrg_forward(wdt_req, req_blocked, autodis_bit, cpu_in_reset);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wdt_rst_out <= 1'b0;
    else        wdt_rst_out <= fwd_now;
  end
endmodule

// File: rtl/wrg_status.sv
module wrg_status (
  input  logic clk,
  input  logic por_n,
  input  logic stat_set,
  input  logic stat_clr,
  output logic stat_bit
);
  // A set and a clear at the same edge: the set wins.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        stat_bit <= 1'b0;
    else if (stat_set) stat_bit <= 1'b1;
    else if (stat_clr) stat_bit <= 1'b0;
  end
endmodule

// File: rtl/wdt_reset_gate.sv
module wdt_reset_gate
  import wrg_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned GATE_POS    = 4,
  parameter int unsigned AUTODIS_POS = 2,
  parameter int unsigned CNTEN_POS   = 0,
  parameter int unsigned STAT_POS    = 1,
  parameter bit          INVERT_MASK = 1'b0
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [WRG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  wdt_req,
  input  logic                  cpu_in_reset,
  output logic                  wdt_rst_out,
  output logic                  wdt_cnt_en
);
  logic gate_bit, autodis_bit, cnten_bit, stat_clr, cnten_wr;
  logic stat_bit, req_blocked, fwd_now;

  wrg_regs #(
    .DATA_W(DATA_W), .GATE_POS(GATE_POS), .AUTODIS_POS(AUTODIS_POS),
    .CNTEN_POS(CNTEN_POS), .STAT_POS(STAT_POS), .INVERT_MASK(INVERT_MASK)
  ) u_regs (
    .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_bit(stat_bit),
    .bus_rdata(bus_rdata), .gate_bit(gate_bit), .autodis_bit(autodis_bit),
    .cnten_bit(cnten_bit), .stat_clr(stat_clr), .cnten_wr(cnten_wr)
  );

  wrg_gate #(.INVERT_MASK(INVERT_MASK)) u_gate (
    .clk(clk), .por_n(por_n), .wdt_req(wdt_req), .cpu_in_reset(cpu_in_reset),
    .gate_bit(gate_bit), .autodis_bit(autodis_bit), .req_blocked(req_blocked),
    .fwd_now(fwd_now), .wdt_rst_out(wdt_rst_out)
  );

  wrg_status u_status (
    .clk(clk), .por_n(por_n), .stat_set(fwd_now), .stat_clr(stat_clr),
    .stat_bit(stat_bit)
  );

  assign wdt_cnt_en = cnten_bit;
endmodule

// File: rtl/wrg_checker.sv
module wrg_checker (
  input logic clk,
  input logic por_n,
  input logic wdt_req,
  input logic cpu_in_reset,
  input logic wdt_rst_out,
  input logic wdt_cnt_en,
  input logic req_blocked,
  input logic autodis_bit,
  input logic stat_bit,
  input logic stat_clr,
  input logic cnten_wr
);
  // R2 and R3: a blocked request never shows at the output one edge later.
  p_blocked_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
    req_blocked |=> !wdt_rst_out);

  p_autodis_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
    (autodis_bit && cpu_in_reset) |=> !wdt_rst_out);

  p_fwd_has_req_r5: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_out |-> $past(wdt_req));

  p_fwd_recorded_r7: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_out |-> stat_bit);

  p_stat_rise_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stat_bit) |-> wdt_rst_out);

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    (stat_bit && !stat_clr) |=> stat_bit);

  p_cnten_rise_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_cnt_en) |-> $past(cnten_wr));
endmodule

bind wdt_reset_gate wrg_checker u_wrg_checker (
  .clk(clk), .por_n(por_n), .wdt_req(wdt_req), .cpu_in_reset(cpu_in_reset),
  .wdt_rst_out(wdt_rst_out), .wdt_cnt_en(wdt_cnt_en), .req_blocked(req_blocked),
  .autodis_bit(autodis_bit), .stat_bit(stat_bit), .stat_clr(stat_clr),
  .cnten_wr(cnten_wr)
);

// File: tb/wdt_reset_gate_test.sv
`timescale 1ns/1ps
module wdt_reset_gate_test;
  localparam int unsigned MP  [2] = '{4, 7};
  localparam int unsigned ADP [2] = '{2, 3};
  localparam int unsigned CEP [2] = '{0, 5};
  localparam int unsigned STP [2] = '{1, 9};
  localparam bit          INV [2] = '{1'b0, 1'b1};

  logic clk = 1'b0, por_n = 1'b0, sel = 1'b0, wr = 1'b0, req = 1'b0, cpu = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rd [2];
  logic        rst_o [2];
  logic        cen [2];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdt_reset_gate #(.GATE_POS(4), .AUTODIS_POS(2), .CNTEN_POS(0), .STAT_POS(1), .INVERT_MASK(1'b0)) uut (
    .clk(clk), .por_n(por_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[0]), .wdt_req(req), .cpu_in_reset(cpu),
    .wdt_rst_out(rst_o[0]), .wdt_cnt_en(cen[0]));

  wdt_reset_gate #(.GATE_POS(7), .AUTODIS_POS(3), .CNTEN_POS(5), .STAT_POS(9), .INVERT_MASK(1'b1)) uut_inv (
    .clk(clk), .por_n(por_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[1]), .wdt_req(req), .cpu_in_reset(cpu),
    .wdt_rst_out(rst_o[1]), .wdt_cnt_en(cen[1]));

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // Behavioural reference model, one entry per instance.
  bit m_gt [2], m_ad [2], m_ce [2], m_st [2], m_out [2];

  function automatic logic [31:0] exp_rd(int i);
    if (!(sel && !wr)) return 32'd0;
    case (addr)
      2'd0:    return 32'(m_gt[i]) << MP[i];
      2'd1:    return 32'(m_ad[i]) << ADP[i];
      2'd2:    return 32'(m_ce[i]) << CEP[i];
      default: return 32'(m_st[i]) << STP[i];
    endcase
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!por_n) begin
        m_gt[i] = !INV[i]; m_ad[i] = 0; m_ce[i] = 0; m_st[i] = 0; m_out[i] = 0;
      end else begin
        bit pass_now;
        bit wnow;
        pass_now = req && (m_gt[i] == INV[i]) && !(m_ad[i] && cpu);
        wnow = sel && wr;
        m_out[i] = pass_now;
        if (pass_now) m_st[i] = 1;
        else if (wnow && addr == 2'd3 && wdata[STP[i]]) m_st[i] = 0;
        if (wnow && addr == 2'd0) m_gt[i] = wdata[MP[i]];
        if (wnow && addr == 2'd1) m_ad[i] = wdata[ADP[i]];
        if (wnow && addr == 2'd2) m_ce[i] = wdata[CEP[i]];
      end
    end
    #1;
    for (int i = 0; i < 2; i++) begin
      chk("R5", "model wdt_rst_out", 32'(rst_o[i]), 32'(m_out[i]));
      chk("R6", "model wdt_cnt_en", 32'(cen[i]), 32'(m_ce[i]));
      chk("R9", "model bus_rdata", rd[i], exp_rd(i));
    end
  end

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] v0, output logic [31:0] v1);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1; v0 = rd[0]; v1 = rd[1];
  endtask

  task automatic drv(logic r, logic c);
    @(negedge clk); req = r; cpu = c; #1;
  endtask

  task automatic tick();
    @(negedge clk); sel = 0; wr = 0; #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    por_n = 1;

    // R1: power-on state
    rreg(2'd0, a, b);
    chk("R1", "gate reg normal", a, 32'h10);
    chk("R1", "gate reg inverted", b, 32'h0);
    rreg(2'd2, a, b);
    chk("R1", "cnten reg", a | b, 32'h0);
    chk("R1", "cnt_en out", 32'(cen[0] | cen[1]), 32'h0);
    drv(1, 0);
    tick(); tick();
    chk("R1", "blocked after reset A", 32'(rst_o[0]), 32'h0);
    chk("R1", "blocked after reset B", 32'(rst_o[1]), 32'h0);

    // R6 and R9: counter enable, only the configured bit
    wreg(2'd2, 32'hFFFF_FFFF);
    chk("R6", "cnt_en A", 32'(cen[0]), 32'h1);
    chk("R6", "cnt_en B", 32'(cen[1]), 32'h1);
    rreg(2'd2, a, b);
    chk("R9", "cnten readback A", a, 32'h1);
    chk("R9", "cnten readback B", b, 32'h20);

    // R2/R3: all ones in the gate register
    wreg(2'd0, 32'hFFFF_FFFF);
    tick();
    chk("R2", "normal gate=1 blocks", 32'(rst_o[0]), 32'h0);
    chk("R3", "inverted gate=1 passes", 32'(rst_o[1]), 32'h1);
    rreg(2'd3, a, b);
    chk("R7", "status A untouched", a, 32'h0);
    chk("R7", "status B set", b, 32'h200);
    rreg(2'd0, a, b);
    chk("R9", "gate readback A", a, 32'h10);
    chk("R9", "gate readback B", b, 32'h80);

    wreg(2'd0, 32'h0);
    tick();
    chk("R2", "normal gate=0 passes", 32'(rst_o[0]), 32'h1);
    chk("R3", "inverted gate=0 blocks", 32'(rst_o[1]), 32'h0);

    // R4: auto-disable
    wreg(2'd1, 32'hFFFF_FFFF);
    tick();
    chk("R4", "autodis, cpu running", 32'(rst_o[0]), 32'h1);
    drv(1, 1);
    chk("R5", "output still old value", 32'(rst_o[0]), 32'h1);
    tick();
    chk("R4", "autodis, cpu in reset", 32'(rst_o[0]), 32'h0);
    drv(1, 0);
    tick();
    chk("R4", "autodis, cpu released", 32'(rst_o[0]), 32'h1);
    wreg(2'd1, 32'h0);
    drv(1, 1);
    tick();
    chk("R4", "no autodis ignores cpu", 32'(rst_o[0]), 32'h1);

    // R5: one edge of latency on removal
    drv(0, 0);
    chk("R5", "held one cycle", 32'(rst_o[0]), 32'h1);
    tick();
    chk("R5", "dropped next edge", 32'(rst_o[0]), 32'h0);

    // R7: sticky
    tick(); tick();
    rreg(2'd3, a, b);
    chk("R7", "sticky A", a, 32'h2);
    chk("R7", "sticky B", b, 32'h200);

    // R8: write-1-to-clear
    wreg(2'd3, ~32'h202);
    rreg(2'd3, a, b);
    chk("R8", "zero write keeps A", a, 32'h2);
    chk("R8", "zero write keeps B", b, 32'h200);
    wreg(2'd3, 32'h2);
    rreg(2'd3, a, b);
    chk("R8", "clear A", a, 32'h0);
    chk("R8", "B kept", b, 32'h200);
    wreg(2'd3, 32'h200);
    rreg(2'd3, a, b);
    chk("R8", "clear B", b, 32'h0);

    // R8: set wins over clear
    drv(1, 0);
    wreg(2'd3, 32'hFFFF_FFFF);
    rreg(2'd3, a, b);
    chk("R8", "set beats clear", a, 32'h2);
    drv(0, 0);
    tick();
    wreg(2'd3, 32'hFFFF_FFFF);
    rreg(2'd3, a, b);
    chk("R8", "clear once quiet", a, 32'h0);

    // R2: re-masking
    wreg(2'd0, 32'h10);
    drv(1, 0);
    tick(); tick();
    chk("R2", "re-masked", 32'(rst_o[0]), 32'h0);
    drv(0, 0);
    tick();

    summary();
    $finish;
  end
endmodule